// File: doc/BRIEF.md
# Signed SAR conversion sequencer

This block sequences a differential charge-redistribution successive-approximation converter and yields a signed result: one sign bit over an unsigned magnitude. A conversion opens with a sampling window. The sample switch is closed for that window, so both capacitor banks track the front-end amplifier. The switch then opens for a run of decision cycles, one per clock, and the latched comparator is enabled for each of them. The first decision resolves the sign. Each later decision tests one magnitude bit, most significant bit first. It drives a binary-weighted trial code onto the per-bit reference-select lines of both banks, and the comparator's answer decides whether the bit is kept.

When the sign comes out negative, the supply assignment of the two banks is reversed for the whole magnitude search, so the same search works on either side of zero. The window length is a 2-bit setting that gives one to four clocks. It is captured when a conversion begins. Conversions run one at a time on a start request, or back to back while free-run is held. At the minimum window one conversion takes ten clocks. The finished code appears on the result bus with a one-cycle valid pulse.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high (synchronous, active high), and on the first cycle after it, `sample_sw` is 1, `cmp_en` is 0, `result_valid` is 0, `result` is 0 and all four select vectors are 0.
- R2: A conversion begins on a cycle in which the block is idle and `start` or `free_run` is 1. That cycle plus `sample_len` further cycles form the sample window (`sample_len` = 0..3 gives 1..4 cycles). `sample_sw` is 1 throughout the window and 0 throughout the decision cycles.
- R3: Exactly nine decision cycles follow the window, with `cmp_en` at 1 in each and never at the same time as `sample_sw`. Back-to-back conversions therefore repeat every `sample_len` + 10 cycles.
- R4: The first decision cycle resolves the sign: `cmp_out` = 0 there gives `result[8]` = 1 (negative), and 1 gives `result[8]` = 0.
- R5: Magnitude decisions run MSB first. In the k-th magnitude cycle (k = 0..7) the trial code is the bits kept so far with bit 7-k added, so the first trial is 128. `result[7:0]` holds the kept bits.
- R6: The select lines are all 0 outside the magnitude cycles, including the sign cycle. In a magnitude cycle a set bit i means capacitor i is switched. With a non-negative sign the trial code drives `pos_hi_sel` and `neg_lo_sel` and the other two stay 0. With a negative sign it drives `pos_lo_sel` and `neg_hi_sel` and the other two stay 0.
- R7: A tested bit is kept when `cmp_out` is 1 under a non-negative sign, and when `cmp_out` is 0 under a negative sign.
- R8: `sample_len` is captured on the cycle a conversion begins. A change during that conversion does not alter its timing.
- R9: `result` changes only on the cycle `result_valid` is 1. `result_valid` lasts exactly one cycle, the cycle after the last magnitude decision.
- R10: With `free_run` held at 1, the cycle carrying `result_valid` is also the first sample cycle of the next conversion. With neither `start` nor `free_run` the block stays idle, with `sample_sw` at 1 and no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one conversion when idle |
| free_run | input | 1 | Convert continuously while high |
| sample_len | input | 2 | Extra sample cycles (window = value + 1) |
| cmp_out | input | 1 | Latched comparator decision |
| sample_sw | output | 1 | Sample switch closed (banks track amplifier) |
| cmp_en | output | 1 | Comparator enabled for a decision this cycle |
| pos_hi_sel | output | 8 | Positive bank bits switched to high reference |
| pos_lo_sel | output | 8 | Positive bank bits switched to low reference |
| neg_hi_sel | output | 8 | Negative bank bits switched to high reference |
| neg_lo_sel | output | 8 | Negative bank bits switched to low reference |
| result | output | 9 | Sign bit (MSB) and magnitude |
| result_valid | output | 1 | One-cycle pulse when result updates |

## Verification
A stuck or skipped bit pointer shows on the select lines in the very next decision cycle as a wrong trial code. It also shows as a wrong decision count, which changes the spacing between valid pulses. A lost or flipped sign register shows within the same conversion as select activity on the wrong pair of lines. Because the comparator model in the bench depends on that polarity, it also returns a wrong magnitude. Errors in the kept-bit register or the sample counter surface at the next valid pulse, as a result differing from the stimulus or as a window of the wrong length.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SAMP = 2'd1,
      ST_SIGN = 2'd2,
      ST_MAG  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
   import sar_seq_pkg::*;
#(
   parameter int MAG_W  = 8,
   parameter int SLEN_W = 2,
   localparam int IDX_W = (MAG_W > 1) ? $clog2(MAG_W) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic [SLEN_W-1:0] samp_len,
   output seq_state_t        state_o,
   output logic [IDX_W-1:0]  bit_idx_o,
   output logic              last_o
);
   seq_state_t        state_q;
   logic [SLEN_W-1:0] cnt_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  cnt_q   <= samp_len;
                  state_q <= (samp_len == '0) ? ST_SIGN : ST_SAMP;
               end
            end
            ST_SAMP: begin
               if (cnt_q == SLEN_W'(1)) state_q <= ST_SIGN;
               cnt_q <= cnt_q - SLEN_W'(1);
            end
            ST_SIGN: begin
               state_q <= ST_MAG;
               idx_q   <= IDX_W'(MAG_W - 1);
            end
            ST_MAG: begin
               if (idx_q == '0) state_q <= ST_IDLE;
               else             idx_q   <= idx_q - IDX_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o   = state_q;
   assign bit_idx_o = idx_q;
   assign last_o    = (state_q == ST_MAG) && (idx_q == '0);

   // R8: captured window count only runs down, never reloads mid-window
   assert_window_count_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SAMP) |=>
         ((state_q == ST_SAMP) && (cnt_q == $past(cnt_q) - SLEN_W'(1))) ||
         ((state_q == ST_SIGN) && ($past(cnt_q) == SLEN_W'(1))));

   assert_window_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SAMP) |-> (cnt_q != '0));

   // R4 R5: sign cycle is followed by the MSB trial
   assert_msb_after_sign_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SIGN) |=> (state_q == ST_MAG) && (idx_q == IDX_W'(MAG_W - 1)));
endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
   import sar_seq_pkg::*;
#(
   parameter int MAG_W = 8,
   localparam int IDX_W = (MAG_W > 1) ? $clog2(MAG_W) : 1,
   localparam int RES_W = MAG_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  seq_state_t       state_i,
   input  logic [IDX_W-1:0] bit_idx_i,
   input  logic             last_i,
   input  logic             cmp_i,
   output logic [MAG_W-1:0] trial_o,
   output logic             swap_o,
   output logic [RES_W-1:0] result_o,
   output logic             valid_o
);
   logic [MAG_W-1:0] code_q;
   logic [MAG_W-1:0] probe;
   logic             sign_q;
   logic             keep;
   logic [RES_W-1:0] res_q;
   logic             vld_q;

   assign probe = MAG_W'(1) << bit_idx_i;
   // negative sign reverses the bank polarity, so the decision sense flips
   assign keep  = cmp_i ^ sign_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         sign_q <= 1'b0;
         res_q  <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (state_i)
            ST_SIGN: begin
               sign_q <= ~cmp_i;
               code_q <= '0;
            end
            ST_MAG: begin
               if (keep) code_q <= code_q | probe;
               if (last_i) begin
                  res_q <= {sign_q, keep ? (code_q | probe) : code_q};
                  vld_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign trial_o  = (state_i == ST_MAG) ? (code_q | probe) : '0;
   assign swap_o   = sign_q;
   assign result_o = res_q;
   assign valid_o  = vld_q;

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      vld_q |=> !vld_q);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !vld_q |-> $stable(res_q));

   assert_sign_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (state_i == ST_MAG && $past(state_i) == ST_MAG) |-> $stable(sign_q));
endmodule

// File: rtl/sar_seq_refdrv.sv
module sar_seq_refdrv #(
   parameter int MAG_W = 8
) (
   input  logic [MAG_W-1:0] trial_i,
   input  logic             swap_i,
   output logic [MAG_W-1:0] pos_hi_o,
   output logic [MAG_W-1:0] pos_lo_o,
   output logic [MAG_W-1:0] neg_hi_o,
   output logic [MAG_W-1:0] neg_lo_o
);
   for (genvar i = 0; i < MAG_W; i++) begin : g_cell
      assign pos_hi_o[i] = trial_i[i] & ~swap_i;
      assign neg_lo_o[i] = trial_i[i] & ~swap_i;
      assign pos_lo_o[i] = trial_i[i] &  swap_i;
      assign neg_hi_o[i] = trial_i[i] &  swap_i;
   end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int MAG_W  = 8,
   parameter int SLEN_W = 2,
   localparam int IDX_W = (MAG_W > 1) ? $clog2(MAG_W) : 1,
   localparam int RES_W = MAG_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              free_run,
   input  logic [SLEN_W-1:0] sample_len,
   input  logic              cmp_out,
   output logic              sample_sw,
   output logic              cmp_en,
   output logic [MAG_W-1:0]  pos_hi_sel,
   output logic [MAG_W-1:0]  pos_lo_sel,
   output logic [MAG_W-1:0]  neg_hi_sel,
   output logic [MAG_W-1:0]  neg_lo_sel,
   output logic [RES_W-1:0]  result,
   output logic              result_valid
);
   if (MAG_W < 2 || MAG_W > 16) begin : g_bad_mag_w
      $error("sar_seq_ctrl: MAG_W must lie in 2..16");
   end
   if (SLEN_W < 1 || SLEN_W > 4) begin : g_bad_slen_w
      $error("sar_seq_ctrl: SLEN_W must lie in 1..4");
   end

   seq_state_t       state;
   logic [IDX_W-1:0] bit_idx;
   logic             last_bit;
   logic [MAG_W-1:0] trial;
   logic             swap;

   sar_seq_fsm #(.MAG_W(MAG_W), .SLEN_W(SLEN_W)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .go       (start | free_run),
      .samp_len (sample_len),
      .state_o  (state),
      .bit_idx_o(bit_idx),
      .last_o   (last_bit)
   );

   sar_seq_datapath #(.MAG_W(MAG_W)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .state_i  (state),
      .bit_idx_i(bit_idx),
      .last_i   (last_bit),
      .cmp_i    (cmp_out),
      .trial_o  (trial),
      .swap_o   (swap),
      .result_o (result),
      .valid_o  (result_valid)
   );

   sar_seq_refdrv #(.MAG_W(MAG_W)) u_ref (
      .trial_i (trial),
      .swap_i  (swap),
      .pos_hi_o(pos_hi_sel),
      .pos_lo_o(pos_lo_sel),
      .neg_hi_o(neg_hi_sel),
      .neg_lo_o(neg_lo_sel)
   );

   assign sample_sw = (state == ST_IDLE) || (state == ST_SAMP);
   assign cmp_en    = (state == ST_SIGN) || (state == ST_MAG);

   assert_sw_cmp_excl_R3: assert property (@(posedge clk) disable iff (rst)
      !(sample_sw && cmp_en));

   // R4 R6: first decision cycle (sign) drives no capacitor
   assert_sign_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(cmp_en) |-> (pos_hi_sel == '0) && (pos_lo_sel == '0) &&
                        (neg_hi_sel == '0) && (neg_lo_sel == '0));

   assert_polarity_keep_hi_R6: assert property (@(posedge clk) disable iff (rst)
      (pos_hi_sel != '0) |=> (pos_lo_sel == '0) && (neg_hi_sel == '0));

   assert_polarity_keep_lo_R6: assert property (@(posedge clk) disable iff (rst)
      (pos_lo_sel != '0) |=> (pos_hi_sel == '0) && (neg_lo_sel == '0));

   assert_valid_in_window_R10: assert property (@(posedge clk) disable iff (rst)
      result_valid |-> sample_sw);
endmodule

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       free_run = 1'b0;
   logic [1:0] sample_len = 2'd0;
   logic       cmp_out;
   logic       sample_sw, cmp_en, result_valid;
   logic [7:0] pos_hi_sel, pos_lo_sel, neg_hi_sel, neg_lo_sel;
   logic [8:0] result;

   int total = 0;
   int bad   = 0;
   int x_val = 0;
   int resid;
   int cycles = 0;

   always #4 clk = ~clk;

   sar_seq_ctrl dut (
      .clk(clk), .rst(rst), .start(start), .free_run(free_run),
      .sample_len(sample_len), .cmp_out(cmp_out),
      .sample_sw(sample_sw), .cmp_en(cmp_en),
      .pos_hi_sel(pos_hi_sel), .pos_lo_sel(pos_lo_sel),
      .neg_hi_sel(neg_hi_sel), .neg_lo_sel(neg_lo_sel),
      .result(result), .result_valid(result_valid)
   );

   // behavioural comparator: residue of the stimulus against the switched trial
   always_comb begin
      resid   = x_val - int'(pos_hi_sel) + int'(pos_lo_sel);
      cmp_out = (resid > 0) || (resid == 0 && pos_lo_sel == 8'd0);
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one conversion from the current negedge up to its valid cycle
   task automatic run_one(input int x_in, input int exp_len, input bit use_start,
                          input int new_len);
      int cyc = 0, smp = 0, dec = 0, first_trial = -1;
      bit wrong_pol = 0, early_valid = 0;
      int exp_res;
      x_val = x_in;
      if (use_start) start = 1'b1;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) start = 1'b0;
         if (cyc == 2 && new_len >= 0) sample_len = 2'(new_len);
         if (sample_sw) smp++;
         if (cmp_en) dec++;
         if (cyc == 1 && result_valid) early_valid = 1;
         if (first_trial < 0 && (pos_hi_sel | pos_lo_sel) != 8'd0)
            first_trial = int'(pos_hi_sel | pos_lo_sel);
         if (x_in < 0 && (pos_hi_sel | neg_lo_sel) != 8'd0) wrong_pol = 1;
         if (x_in >= 0 && (pos_lo_sel | neg_hi_sel) != 8'd0) wrong_pol = 1;
         if (x_in < 0 && pos_lo_sel != neg_hi_sel) wrong_pol = 1;
         if (x_in >= 0 && pos_hi_sel != neg_lo_sel) wrong_pol = 1;
      end while (!result_valid && cyc < 100);
      exp_res = (x_in < 0) ? (256 + (-x_in)) : x_in;
      chk(result_valid, "R3 conversion completes", cyc, exp_len + 10);
      chk(cyc == exp_len + 10, "R3 R8 conversion period", cyc, exp_len + 10);
      chk(smp == exp_len + 1, "R2 sample window length", smp, exp_len + 1);
      chk(dec == 9, "R3 decision cycles", dec, 9);
      chk(result[8] == (x_in < 0), "R4 sign bit", int'(result[8]), int'(x_in < 0));
      chk(int'(result) == exp_res, (x_in < 0) ? "R5 R7 negative magnitude" : "R5 R7 magnitude",
          int'(result), exp_res);
      if (x_in != 0 && x_in != -1 && x_in != 1)
         chk(first_trial == 128, "R5 MSB first trial", first_trial, 128);
      chk(!wrong_pol, "R6 bank polarity", int'(wrong_pol), 0);
      chk(!early_valid, "R9 single-cycle valid", int'(early_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sample_sw == 1'b1, "R1 sample_sw in reset", int'(sample_sw), 1);
      chk(!cmp_en && !result_valid, "R1 cmp_en/valid in reset",
          int'({cmp_en, result_valid}), 0);
      chk(result == 9'd0, "R1 result in reset", int'(result), 0);
      chk((pos_hi_sel | pos_lo_sel | neg_hi_sel | neg_lo_sel) == 8'd0,
          "R1 selects in reset", int'(pos_hi_sel | pos_lo_sel), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(sample_sw && !cmp_en && !result_valid, "R1 state after reset",
          int'({sample_sw, cmp_en, result_valid}), 4);

      // R10: no request, block stays idle
      begin
         bit moved = 0;
         for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (!sample_sw || cmp_en || result_valid) moved = 1;
         end
         chk(!moved, "R10 idle without request", int'(moved), 0);
      end

      // R2 R3 R10: full sweep in free-run at minimum window
      free_run   = 1'b1;
      sample_len = 2'd0;
      for (int v = -255; v <= 255; v++) run_one(v, 0, 1'b0, -1);

      // longer windows, still back to back; new length set in the valid cycle
      sample_len = 2'd3;
      for (int v = -255; v <= 255; v += 17) run_one(v, 3, 1'b0, -1);
      sample_len = 2'd1;
      for (int v = -200; v <= 200; v += 50) run_one(v, 1, 1'b0, -1);
      sample_len = 2'd2;
      for (int v = -129; v <= 129; v += 43) run_one(v, 2, 1'b0, -1);
      free_run = 1'b0;

      // R8: single-shot starts, length changed during the conversion
      @(negedge clk);
      sample_len = 2'd0;
      run_one(-77, 0, 1'b1, 3);
      sample_len = 2'd2;
      @(negedge clk);
      run_one(200, 2, 1'b1, 0);
      sample_len = 2'd3;
      @(negedge clk);
      run_one(-255, 3, 1'b1, 1);

      // R9 R10: after a single shot the block returns to idle with no valid
      begin
         bit moved = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (result_valid || cmp_en) moved = 1;
         end
         chk(!moved, "R10 R9 idle after single shot", int'(moved), 0);
         chk(int'(result) == 256 + 255, "R9 result held while idle", int'(result), 511);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule